// File: doc/BRIEF.md
# Movement Onset Detection Post-Processor

This block cleans up a per-period onset score stream before it leaves the decoder. Each accepted input beat carries a signed regression score and a movement class label. The score is compared against a programmable threshold to give a hit bit. A shift history holds the latest hit bits, and a vote reports whether enough of the most recent beats were hits. A detection opens only on the beat where that vote turns on and no hold-off is running. It stays open while the vote holds. When it closes, a hold-off of a programmable number of beats follows. During the hold-off the output is forced low and new detections are refused. The hit history keeps filling during the hold-off.

Every accepted beat produces exactly one output beat. That beat carries the class label while a detection is open and zero otherwise, plus a one-bit tracked flag. Input and output are valid/ready streams with a single output register between them. The block takes an input beat only when that register is empty or is being drained in the same cycle, so `s_ready = !m_valid || m_ready`. A stalled output keeps its value and holds off the input. Nothing advances without an accepted input beat.

Top module: `onset_detect_pp`

## Requirements
- R1: A beat is a hit only when its score, read as two's complement, is strictly greater than the threshold. A score equal to the threshold, or any lower value, is not a hit.
- R2: The vote is on when the number of hits among the most recent `span` accepted beats is at least `min_hits`. The current beat counts as one of those beats.
- R3: A detection opens only on a beat where the vote is on and was off on the previous beat, and no hold-off is running. An open detection stays open on every following beat whose vote is on.
- R4: On the beat where the vote of an open detection turns off, the detection closes and a hold-off of `hold` beats starts. During those beats the output is zero and rising votes are ignored. The hit history keeps updating.
- R5: Each output beat carries the input label of the same beat when its detection is open (`m_track` = 1), and all zeros otherwise (`m_track` = 0).
- R6: `s_ready` equals `!m_valid || m_ready`. While `m_valid` is high and `m_ready` is low, the output beat stays unchanged and no input beat is taken. With `m_ready` high and no new beat, `m_valid` drops.
- R7: The threshold, `min_hits`, `span` and `hold` registers load from their configuration inputs on any clock where `cfg_en` is high. After reset they hold threshold 0, min_hits 6, span 10 and hold 7.
- R8: A synchronous reset empties the hit history, clears the hold-off and any open detection, drops `m_valid` and zeroes the output beat.
- R9: A `span` larger than the history depth (16) acts as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Loads the four configuration registers |
| cfg_theta | input | 16 | Signed score threshold |
| cfg_min_hits | input | 5 | Hits needed for the vote |
| cfg_span | input | 5 | Number of recent beats examined |
| cfg_hold | input | 8 | Hold-off length in beats |
| s_valid | input | 1 | Input beat present |
| s_ready | output | 1 | Input beat is taken this cycle if valid |
| s_score | input | 16 | Signed onset score |
| s_label | input | 4 | Movement class label |
| m_valid | output | 1 | Output beat present |
| m_ready | input | 1 | Consumer takes the output beat |
| m_track | output | 1 | Detection open on this beat |
| m_label | output | 4 | Gated label, zero when not tracked |

## Verification
A fixed score sequence is run against a small span, and each pattern separates a different behaviour. The sequence includes a score equal to the threshold and a negative score below it, which separate strict from non-strict and signed from unsigned comparison. It also includes isolated hits that fall short of the vote, and a vote that turns on, opens a detection and then closes. After the close comes a run of hits that rises during the hold-off and stays high after it, which shows that a detection opens only on an edge outside the hold-off. A second detection changes its label mid-detection, which shows the label is passed per beat. Separate runs check the reset defaults, a span above the history depth with a full-depth vote, a history cleared by a mid-run reset, and an output stall that must neither lose nor duplicate a beat.

// File: rtl/onset_pkg.sv
package onset_pkg;
  localparam int SCORE_W_D  = 16;
  localparam int LABEL_W_D  = 4;
  localparam int HIST_N_D   = 16;
  localparam int HOLD_W_D   = 8;

  localparam int THETA_RST    = 0;
  localparam int MIN_HITS_RST = 6;
  localparam int SPAN_RST     = 10;
  localparam int HOLD_RST     = 7;
endpackage

// File: rtl/onset_cfg.sv
module onset_cfg
  import onset_pkg::*;
#(
  parameter int SCORE_W = SCORE_W_D,
  parameter int CNT_W   = 5,
  parameter int HOLD_W  = HOLD_W_D
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_en,
  input  logic signed [SCORE_W-1:0] in_theta,
  input  logic        [CNT_W-1:0]   in_min_hits,
  input  logic        [CNT_W-1:0]   in_span,
  input  logic        [HOLD_W-1:0]  in_hold,
  output logic signed [SCORE_W-1:0] theta,
  output logic        [CNT_W-1:0]   min_hits,
  output logic        [CNT_W-1:0]   span,
  output logic        [HOLD_W-1:0]  hold
);
  always_ff @(posedge clk) begin
    if (rst) begin
      theta    <= SCORE_W'(THETA_RST);
      min_hits <= CNT_W'(MIN_HITS_RST);
      span     <= CNT_W'(SPAN_RST);
      hold     <= HOLD_W'(HOLD_RST);
    end else if (cfg_en) begin
      theta    <= in_theta;
      min_hits <= in_min_hits;
      span     <= in_span;
      hold     <= in_hold;
    end
  end

  // R7: a load is visible on the next clock
  a_r7_cfg_load: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (min_hits == $past(in_min_hits)) && (hold == $past(in_hold)));
endmodule

// File: rtl/onset_vote.sv
module onset_vote
  import onset_pkg::*;
#(
  parameter int SCORE_W = SCORE_W_D,
  parameter int HIST_N  = HIST_N_D,
  parameter int CNT_W   = $clog2(HIST_N + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      beat,
  input  logic signed [SCORE_W-1:0] score,
  input  logic signed [SCORE_W-1:0] theta,
  input  logic        [CNT_W-1:0]   min_hits,
  input  logic        [CNT_W-1:0]   span,
  output logic                      vote_now,
  output logic                      vote_prev
);
  logic [HIST_N-1:0] hist_q;
  logic [HIST_N-1:0] hist_d;
  logic [HIST_N-1:0] win_mask;
  logic [CNT_W-1:0]  span_eff;
  logic [CNT_W-1:0]  hit_cnt;
  logic              hit;

  assign hit    = (score > theta);
  assign hist_d = {hist_q[HIST_N-2:0], hit};

  always_comb begin
    if (int'(span) > HIST_N) span_eff = CNT_W'(HIST_N);
    else                     span_eff = span;
  end

  for (genvar gi = 0; gi < HIST_N; gi++) begin : g_mask
    assign win_mask[gi] = (gi < int'(span_eff));
  end

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < HIST_N; i++)
      hit_cnt = hit_cnt + CNT_W'(hist_d[i] & win_mask[i]);
  end

  assign vote_now = (hit_cnt >= min_hits);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q    <= '0;
      vote_prev <= 1'b0;
    end else if (beat) begin
      hist_q    <= hist_d;
      vote_prev <= vote_now;
    end
  end

  // R9: the tally never exceeds the effective window
  a_r9_cnt_in_window: assert property (@(posedge clk) disable iff (rst)
    beat |-> (hit_cnt <= span_eff) && (span_eff <= CNT_W'(HIST_N)));

  // R2: without a beat the remembered vote stays put
  a_r2_vote_held: assert property (@(posedge clk) disable iff (rst)
    !beat |=> $stable(vote_prev));
endmodule

// File: rtl/onset_lockout.sv
module onset_lockout
  import onset_pkg::*;
#(
  parameter int HOLD_W = HOLD_W_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic              vote_now,
  input  logic              vote_prev,
  input  logic [HOLD_W-1:0] hold,
  output logic              track_next
);
  logic              active_q;
  logic [HOLD_W-1:0] rcnt_q;
  logic              lock_on;

  assign lock_on = (rcnt_q != '0);

  always_comb begin
    if (lock_on)       track_next = 1'b0;
    else if (active_q) track_next = vote_now;
    else               track_next = vote_now && !vote_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rcnt_q   <= '0;
    end else if (beat) begin
      active_q <= track_next;
      if (lock_on)
        rcnt_q <= rcnt_q - 1'b1;
      else if (active_q && !vote_now)
        rcnt_q <= hold;
    end
  end

  // R4: no open detection while the hold-off counts
  a_r4_quiet_in_hold: assert property (@(posedge clk) disable iff (rst)
    lock_on |-> !active_q);

  // R3: a detection opens only after a rising vote outside the hold-off
  a_r3_open_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> vote_prev && ($past(rcnt_q) == '0) && $past(beat));
endmodule

// File: rtl/onset_detect_pp.sv
module onset_detect_pp
  import onset_pkg::*;
#(
  parameter int SCORE_W = SCORE_W_D,
  parameter int LABEL_W = LABEL_W_D,
  parameter int HIST_N  = HIST_N_D,
  parameter int HOLD_W  = HOLD_W_D,
  localparam int CNT_W  = $clog2(HIST_N + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_en,
  input  logic signed [SCORE_W-1:0] cfg_theta,
  input  logic        [CNT_W-1:0]   cfg_min_hits,
  input  logic        [CNT_W-1:0]   cfg_span,
  input  logic        [HOLD_W-1:0]  cfg_hold,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic signed [SCORE_W-1:0] s_score,
  input  logic        [LABEL_W-1:0] s_label,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic                      m_track,
  output logic        [LABEL_W-1:0] m_label
);
  logic signed [SCORE_W-1:0] theta;
  logic        [CNT_W-1:0]   min_hits;
  logic        [CNT_W-1:0]   span;
  logic        [HOLD_W-1:0]  hold;
  logic                      vote_now;
  logic                      vote_prev;
  logic                      track_next;
  logic                      beat;

  assign s_ready = !m_valid || m_ready;
  assign beat    = s_valid && s_ready;

  onset_cfg #(.SCORE_W(SCORE_W), .CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_en(cfg_en),
    .in_theta(cfg_theta), .in_min_hits(cfg_min_hits),
    .in_span(cfg_span), .in_hold(cfg_hold),
    .theta(theta), .min_hits(min_hits), .span(span), .hold(hold)
  );

  onset_vote #(.SCORE_W(SCORE_W), .HIST_N(HIST_N), .CNT_W(CNT_W)) u_vote (
    .clk(clk), .rst(rst), .beat(beat), .score(s_score),
    .theta(theta), .min_hits(min_hits), .span(span),
    .vote_now(vote_now), .vote_prev(vote_prev)
  );

  onset_lockout #(.HOLD_W(HOLD_W)) u_lock (
    .clk(clk), .rst(rst), .beat(beat),
    .vote_now(vote_now), .vote_prev(vote_prev), .hold(hold),
    .track_next(track_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_track <= 1'b0;
      m_label <= '0;
    end else if (beat) begin
      m_valid <= 1'b1;
      m_track <= track_next;
      m_label <= track_next ? s_label : '0;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R6: a stalled beat is held unchanged
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> m_valid && $stable(m_label) && $stable(m_track));

  // R6: an empty output register always accepts
  a_r6_ready_empty: assert property (@(posedge clk) disable iff (rst)
    !m_valid |-> s_ready);

  // R5: untracked beats carry no label
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_track) |-> (m_label == '0));

  // R8: the clock after reset leaves the output empty
  a_r8_reset_empty: assert property (@(posedge clk)
    $past(rst) |-> !m_valid && !m_track);
endmodule

// File: tb/onset_detect_pp_tb.sv
`timescale 1ns/1ps
module onset_detect_pp_tb;
  localparam int NROW = 17;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfg_en = 1'b0;
  logic signed [15:0] cfg_theta = '0;
  logic        [4:0]  cfg_min_hits = '0;
  logic        [4:0]  cfg_span = '0;
  logic        [7:0]  cfg_hold = '0;
  logic               s_valid = 1'b0;
  logic               s_ready;
  logic signed [15:0] s_score = '0;
  logic        [3:0]  s_label = '0;
  logic               m_valid;
  logic               m_ready = 1'b1;
  logic               m_track;
  logic        [3:0]  m_label;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  onset_detect_pp u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_theta(cfg_theta),
    .cfg_min_hits(cfg_min_hits), .cfg_span(cfg_span), .cfg_hold(cfg_hold),
    .s_valid(s_valid), .s_ready(s_ready), .s_score(s_score), .s_label(s_label),
    .m_valid(m_valid), .m_ready(m_ready), .m_track(m_track), .m_label(m_label)
  );

  // threshold 10, min_hits 2, span 3, hold 2
  localparam int    T_SCORE [NROW] = '{5, 10, 11, -20, 50, 0, 100, 100, 100,
                                       0, 0, 0, 20, 20, 20, -1, -1};
  localparam int    T_LABEL [NROW] = '{3, 3, 3, 3, 3, 3, 3, 3, 3,
                                       3, 3, 3, 7, 7, 9, 9, 9};
  localparam int    T_EXP   [NROW] = '{0, 0, 0, 0, 3, 0, 0, 0, 0,
                                       0, 0, 0, 0, 7, 9, 9, 0};
  localparam string T_REQ   [NROW] = '{"R1", "R1", "R2", "R1", "R3", "R4", "R4",
                                       "R4", "R3", "R2", "R2", "R2", "R2",
                                       "R5", "R5", "R2", "R4"};

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_cfg(input int th, input int mh, input int sp, input int hd);
    cfg_en = 1'b1;
    cfg_theta = 16'(th);
    cfg_min_hits = 5'(mh);
    cfg_span = 5'(sp);
    cfg_hold = 8'(hd);
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  // drive one beat at a negedge, check its output beat at the next negedge
  task automatic send(input int sc, input int lb, input int exp, input string req);
    s_valid = 1'b1;
    s_score = 16'(sc);
    s_label = 4'(lb);
    @(negedge clk);
    s_valid = 1'b0;
    check(req, "m_valid", int'(m_valid), 1);
    check(req, "m_label", int'(m_label), exp);
    check(req, "m_track", int'(m_track), int'(exp != 0));
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R8: reset state
    check("R8", "m_valid after reset", int'(m_valid), 0);
    check("R8", "m_label after reset", int'(m_label), 0);
    check("R6", "s_ready when empty", int'(s_ready), 1);

    // R7: defaults threshold 0, min_hits 6, span 10
    for (int i = 1; i <= 6; i++) send(1, 5, (i == 6) ? 5 : 0, "R7");

    // main table
    do_reset();
    load_cfg(10, 2, 3, 2);
    for (int r = 0; r < NROW; r++) send(T_SCORE[r], T_LABEL[r], T_EXP[r], T_REQ[r]);

    // R9: span 20 acts as 16, vote needs all 16 hits
    do_reset();
    load_cfg(-5, 16, 20, 0);
    for (int i = 1; i <= 16; i++) send(0, 6, (i == 16) ? 6 : 0, "R9");

    // R8: mid-run reset empties the full history and open detection
    do_reset();
    check("R8", "m_track after mid reset", int'(m_track), 0);
    load_cfg(0, 2, 3, 0);
    send(1, 2, 0, "R8");

    // R6: stall behaviour
    load_cfg(0, 1, 1, 0);
    send(0, 2, 0, "R6");
    m_ready = 1'b0;
    #0;
    check("R6", "s_ready during stall", int'(s_ready), 0);
    s_valid = 1'b1;
    s_score = 16'sd5;
    s_label = 4'd4;
    @(negedge clk);
    check("R6", "m_valid held", int'(m_valid), 1);
    check("R6", "m_label held", int'(m_label), 0);
    m_ready = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check("R6", "stalled beat delivered", int'(m_label), 4);
    check("R3", "stalled beat opens detection", int'(m_track), 1);
    @(negedge clk);
    check("R6", "m_valid drops when drained", int'(m_valid), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule